// File: doc/BRIEF.md
# Banked Effective Address Generator

This block turns an addressing-mode code, the operand bytes that the fetch stage has already collected, and a snapshot of the processor's index, direct, stack and bank registers into a 24-bit effective address. A 24-bit address is a bank byte placed above a 16-bit offset. Each mode picks its own bank source: the data bank, the program bank, bank zero, or a bank byte carried inside the operand or a pointer. Most offset arithmetic wraps within 16 bits. The long modes carry across all 24 bits.

A request is accepted on a `start` pulse, and every input the block needs is captured at that edge. Direct modes return the address one cycle later. Indirect modes first fetch a 2- or 3-byte pointer from bank zero through a synchronous byte read port, low byte first, with one read per cycle. They then combine the pointer with the data bank and the Y index and return the final address with a one-cycle `done` strobe. The block raises `busy` while a pointer fetch is in flight, and ignores any `start` that arrives during that time.

Top module: `bank_ea_unit`

## Requirements
- R1: After a synchronous reset, `done`, `busy` and `mem_rd_en` are 0 and `ea` is 0.
- R2: Mode 0 (absolute) returns the bank `pbank` when `ctl_flow`=1 and `dbank` otherwise, above `opnd[15:0]`. Every direct mode (codes 0-4, 9, 11-15) raises `done` in the cycle after the accepting edge.
- R3: Mode 1 (absolute+X) and mode 2 (absolute+Y) return `dbank` above (`opnd[15:0]` + index) mod 65536.
- R4: When `idx8`=1, only bits 7..0 of X or Y, zero-extended, take part in every indexed mode (1, 2, 4, 6, 8, 10, 12).
- R5: Mode 3 (direct) returns bank 0 above (`reg_d` + `opnd[7:0]`) mod 65536. Mode 4 (direct+X) adds the X index to that sum inside the same 16-bit wrap.
- R6: Mode 9 (stack relative) returns bank 0 above (`reg_sp` + `opnd[7:0]`) mod 65536.
- R7: Mode 11 (long) returns `opnd`. Mode 12 (long+X) returns (`opnd` + X index) mod 2^24, so a carry reaches the bank byte. Codes 13-15 behave as mode 11.
- R8: The indirect modes 5-8 read their pointer at base `reg_d`+`opnd[7:0]`, and mode 10 reads at base `reg_sp`+`opnd[7:0]`. The block reads byte k at bank 0, offset (base+k) mod 65536, low byte first. It issues one read per cycle, starting in the cycle after acceptance. Modes 5, 6 and 10 read 2 bytes; modes 7 and 8 read 3.
- R9: Mode 5 returns `dbank` above the 16-bit pointer. Modes 6 and 10 return `dbank` above (pointer + Y index) mod 65536, with no carry into the bank.
- R10: Mode 7 returns the 24-bit pointer. Mode 8 returns (pointer + Y index) mod 2^24.
- R11: For an indirect request, `done` is high for one cycle, two cycles after the cycle of the last pointer read. `busy` is high from the cycle after acceptance up to, but not including, the `done` cycle.
- R12: The block ignores a `start` pulse while `busy` is high. The request in flight completes unchanged, and no extra `done` follows.
- R13: All request inputs are sampled only at the accepting edge. Changing them afterwards does not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, accepted when not busy |
| mode | input | 4 | Addressing-mode code |
| ctl_flow | input | 1 | Absolute mode targets program bank when 1 |
| opnd | input | 24 | Operand bytes, low byte in bits 7..0 |
| reg_x | input | 16 | X index register |
| reg_y | input | 16 | Y index register |
| reg_d | input | 16 | Direct page register |
| reg_sp | input | 16 | Stack pointer |
| dbank | input | 8 | Data bank |
| pbank | input | 8 | Program bank |
| idx8 | input | 1 | Narrow (8-bit) index registers when 1 |
| mem_rd_en | output | 1 | Pointer byte read request |
| mem_addr | output | 24 | Pointer byte address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| ea | output | 24 | Effective address |
| done | output | 1 | Result strobe, one cycle |
| busy | output | 1 | Pointer fetch in progress |

## Verification
The hardest case to reach is the narrow window in which a pointer fetch is in flight. During that window a second `start` arrives and the captured inputs change, and the result must still follow the original request. The stimulus handles this in three ways. It scrambles every request input right after acceptance. It pulses `start` with a different mode during the first read cycle. It places pointer bases at offset 0xFFFF, so the byte reads wrap inside bank zero. Large Y values force the 16-bit pointer sum to wrap without touching the bank, and the same values force the long sum to carry into the bank.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    AM_ABS        = 4'd0,
    AM_ABS_X      = 4'd1,
    AM_ABS_Y      = 4'd2,
    AM_DP         = 4'd3,
    AM_DP_X       = 4'd4,
    AM_DP_IND     = 4'd5,
    AM_DP_IND_Y   = 4'd6,
    AM_DP_IND_L   = 4'd7,
    AM_DP_IND_L_Y = 4'd8,
    AM_SR         = 4'd9,
    AM_SR_IND_Y   = 4'd10,
    AM_LONG       = 4'd11,
    AM_LONG_X     = 4'd12
  } amode_e;

  localparam logic [3:0] AM_LAST = 4'd12;
endpackage

// File: rtl/ea_base_calc.sv
module ea_base_calc
  import ea_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int OFS_W  = 16
) (
  input  amode_e                    mode,
  input  logic [BANK_W+OFS_W-1:0]   opnd,
  input  logic [OFS_W-1:0]          reg_x,
  input  logic [OFS_W-1:0]          reg_y,
  input  logic [OFS_W-1:0]          reg_d,
  input  logic [OFS_W-1:0]          reg_sp,
  input  logic [BANK_W-1:0]         dbank,
  input  logic [BANK_W-1:0]         pbank,
  input  logic                      idx8,
  input  logic                      ctl_flow,
  output logic [BANK_W+OFS_W-1:0]   direct_ea,
  output logic                      is_ind,
  output logic                      long_ptr,
  output logic [OFS_W-1:0]          ptr_base,
  output logic [OFS_W-1:0]          yidx
);
  localparam int AW = BANK_W + OFS_W;
  localparam int BW = BANK_W;

  logic [OFS_W-1:0] xidx, op8, op16, dp_off, sr_off;

  // narrow index mode keeps only the low byte (R4)
  assign xidx   = idx8 ? {{(OFS_W-BW){1'b0}}, reg_x[BW-1:0]} : reg_x;
  assign yidx   = idx8 ? {{(OFS_W-BW){1'b0}}, reg_y[BW-1:0]} : reg_y;
  assign op8    = {{(OFS_W-BW){1'b0}}, opnd[BW-1:0]};
  assign op16   = opnd[OFS_W-1:0];
  assign dp_off = reg_d + op8;
  assign sr_off = reg_sp + op8;

  always_comb begin
    direct_ea = '0;
    is_ind    = 1'b0;
    long_ptr  = 1'b0;
    ptr_base  = dp_off;
    case (mode)
      AM_ABS:        direct_ea = {(ctl_flow ? pbank : dbank), op16};
      AM_ABS_X:      direct_ea = {dbank, op16 + xidx};
      AM_ABS_Y:      direct_ea = {dbank, op16 + yidx};
      AM_DP:         direct_ea = {{BW{1'b0}}, dp_off};
      AM_DP_X:       direct_ea = {{BW{1'b0}}, dp_off + xidx};
      AM_SR:         direct_ea = {{BW{1'b0}}, sr_off};
      AM_DP_IND,
      AM_DP_IND_Y:   is_ind = 1'b1;
      AM_DP_IND_L,
      AM_DP_IND_L_Y: begin
        is_ind   = 1'b1;
        long_ptr = 1'b1;
      end
      AM_SR_IND_Y: begin
        is_ind   = 1'b1;
        ptr_base = sr_off;
      end
      AM_LONG_X:     direct_ea = opnd + {{BW{1'b0}}, xidx};
      default:       direct_ea = opnd;
    endcase
  end

  always_comb begin
    assert_narrow_index_R4 : assert (!idx8 || (yidx[OFS_W-1:BW] == '0));
  end
endmodule

// File: rtl/ea_ptr_seq.sv
module ea_ptr_seq #(
  parameter int BANK_W = 8,
  parameter int OFS_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      go,
  input  logic                      long_ptr,
  input  logic [OFS_W-1:0]          base,
  input  logic [BANK_W-1:0]         mem_rdata,
  output logic                      mem_rd_en,
  output logic [BANK_W+OFS_W-1:0]   mem_addr,
  output logic [BANK_W+OFS_W-1:0]   ptr_next,
  output logic                      fin
);
  localparam int AW   = BANK_W + OFS_W;
  localparam int BW   = BANK_W;
  localparam int NB_L = AW / BW;
  localparam int NB_S = OFS_W / BW;
  localparam int CW   = $clog2(NB_L + 1);

  logic [CW-1:0] iss_cnt, cap_cnt, nbytes;
  logic          rd_q;
  logic [AW-1:0] ptr_q;

  // bypass the arriving byte into its slot of the pointer
  for (genvar g = 0; g < NB_L; g++) begin : g_slot
    assign ptr_next[g*BW +: BW] = (rd_q && (cap_cnt == CW'(g))) ? mem_rdata
                                                                 : ptr_q[g*BW +: BW];
  end

  assign fin = rd_q && (cap_cnt == nbytes - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rd_en <= 1'b0;
      mem_addr  <= '0;
      iss_cnt   <= '0;
      cap_cnt   <= '0;
      nbytes    <= '0;
      rd_q      <= 1'b0;
      ptr_q     <= '0;
    end else begin
      rd_q <= mem_rd_en;
      if (go) begin
        mem_rd_en <= 1'b1;
        mem_addr  <= {{BW{1'b0}}, base};
        iss_cnt   <= CW'(1);
        cap_cnt   <= '0;
        nbytes    <= long_ptr ? CW'(NB_L) : CW'(NB_S);
        ptr_q     <= '0;
      end else begin
        if (mem_rd_en) begin
          if (iss_cnt == nbytes) begin
            mem_rd_en <= 1'b0;
          end else begin
            mem_addr <= {{BW{1'b0}}, mem_addr[OFS_W-1:0] + OFS_W'(1)};
            iss_cnt  <= iss_cnt + CW'(1);
          end
        end
        if (rd_q) begin
          ptr_q   <= ptr_next;
          cap_cnt <= cap_cnt + CW'(1);
        end
      end
    end
  end

  assert_ptr_bank0_R8 : assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (mem_addr[AW-1:OFS_W] == '0));

  assert_ptr_step_R8 : assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en) && !$past(go)) |->
      (mem_addr[OFS_W-1:0] == $past(mem_addr[OFS_W-1:0]) + OFS_W'(1)));

  assert_issue_bound_R8 : assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> ((iss_cnt != '0) && (iss_cnt <= nbytes)));
endmodule

// File: rtl/ea_final.sv
module ea_final
  import ea_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int OFS_W  = 16
) (
  input  amode_e                    mode,
  input  logic [BANK_W+OFS_W-1:0]   ptr,
  input  logic [BANK_W-1:0]         dbank,
  input  logic [OFS_W-1:0]          yidx,
  output logic [BANK_W+OFS_W-1:0]   ind_ea
);
  always_comb begin
    case (mode)
      AM_DP_IND:     ind_ea = {dbank, ptr[OFS_W-1:0]};
      AM_DP_IND_Y,
      AM_SR_IND_Y:   ind_ea = {dbank, ptr[OFS_W-1:0] + yidx};
      AM_DP_IND_L_Y: ind_ea = ptr + {{BANK_W{1'b0}}, yidx};
      default:       ind_ea = ptr;
    endcase
  end
endmodule

// File: rtl/bank_ea_unit.sv
module bank_ea_unit
  import ea_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int OFS_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [3:0]                mode,
  input  logic                      ctl_flow,
  input  logic [BANK_W+OFS_W-1:0]   opnd,
  input  logic [OFS_W-1:0]          reg_x,
  input  logic [OFS_W-1:0]          reg_y,
  input  logic [OFS_W-1:0]          reg_d,
  input  logic [OFS_W-1:0]          reg_sp,
  input  logic [BANK_W-1:0]         dbank,
  input  logic [BANK_W-1:0]         pbank,
  input  logic                      idx8,
  output logic                      mem_rd_en,
  output logic [BANK_W+OFS_W-1:0]   mem_addr,
  input  logic [BANK_W-1:0]         mem_rdata,
  output logic [BANK_W+OFS_W-1:0]   ea,
  output logic                      done,
  output logic                      busy
);
  localparam int AW = BANK_W + OFS_W;

  amode_e           mode_n, mode_q;
  logic [AW-1:0]    direct_ea, ptr_next, ind_ea;
  logic             is_ind, long_ptr, fin, accept;
  logic [OFS_W-1:0] ptr_base, yidx, yidx_q;
  logic [BANK_W-1:0] dbank_q;

  // unused codes fall back to the long mode (R7)
  assign mode_n = (mode > AM_LAST) ? AM_LONG : amode_e'(mode);
  assign accept = start && !busy;

  ea_base_calc #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_base (
    .mode(mode_n), .opnd(opnd), .reg_x(reg_x), .reg_y(reg_y), .reg_d(reg_d),
    .reg_sp(reg_sp), .dbank(dbank), .pbank(pbank), .idx8(idx8),
    .ctl_flow(ctl_flow), .direct_ea(direct_ea), .is_ind(is_ind),
    .long_ptr(long_ptr), .ptr_base(ptr_base), .yidx(yidx)
  );

  ea_ptr_seq #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_seq (
    .clk(clk), .rst(rst), .go(accept && is_ind), .long_ptr(long_ptr),
    .base(ptr_base), .mem_rdata(mem_rdata), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .ptr_next(ptr_next), .fin(fin)
  );

  ea_final #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_final (
    .mode(mode_q), .ptr(ptr_next), .dbank(dbank_q), .yidx(yidx_q),
    .ind_ea(ind_ea)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ea      <= '0;
      done    <= 1'b0;
      busy    <= 1'b0;
      mode_q  <= AM_ABS;
      dbank_q <= '0;
      yidx_q  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (is_ind) begin
          busy    <= 1'b1;
          mode_q  <= mode_n;
          dbank_q <= dbank;
          yidx_q  <= yidx;
        end else begin
          ea   <= direct_ea;
          done <= 1'b1;
        end
      end else if (fin) begin
        ea   <= ind_ea;
        done <= 1'b1;
        busy <= 1'b0;
      end
    end
  end

  assert_direct_latency_R2 : assert property (@(posedge clk) disable iff (rst)
    (accept && !is_ind) |=> (done && !busy));

  assert_ind_accept_R11 : assert property (@(posedge clk) disable iff (rst)
    (accept && is_ind) |=> (busy && !done && mem_rd_en));

  assert_no_done_busy_R11 : assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  assert_ignore_start_R12 : assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(mode_q) && $stable(dbank_q) && $stable(yidx_q)));

  assert_idle_no_read_R8 : assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> !mem_rd_en);
endmodule

// File: tb/bank_ea_unit_test.sv
`timescale 1ns/1ps
module bank_ea_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic        ctl_flow = 1'b0;
  logic [23:0] opnd = '0;
  logic [15:0] reg_x = '0, reg_y = '0, reg_d = '0, reg_sp = '0;
  logic [7:0]  dbank = '0, pbank = '0;
  logic        idx8 = 1'b0;
  logic        mem_rd_en;
  logic [23:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic [23:0] ea;
  logic        done, busy;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bank_ea_unit uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .ctl_flow(ctl_flow),
    .opnd(opnd), .reg_x(reg_x), .reg_y(reg_y), .reg_d(reg_d), .reg_sp(reg_sp),
    .dbank(dbank), .pbank(pbank), .idx8(idx8), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .ea(ea), .done(done), .busy(busy)
  );

  function automatic logic [7:0] memf(input logic [23:0] a);
    int v;
    v = int'(a[7:0]) * 7 + int'(a[15:8]) * 13 + int'(a[23:16]) + 90;
    return v[7:0];
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= memf(mem_addr);

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: expected address, pointer byte count, pointer base
  task automatic model(input int m, input int op, input bit ctl,
                       input int x, input int y, input int d, input int sp,
                       input int db, input int pb, input bit i8,
                       output int exp_ea, output int nb, output int base);
    int xi, yi, op8, op16, p;
    xi = i8 ? (x & 255) : x;
    yi = i8 ? (y & 255) : y;
    op8 = op & 255;
    op16 = op & 65535;
    if (m > 12) m = 11;
    nb = 0; base = 0; exp_ea = 0;
    case (m)
      0: exp_ea = ((ctl ? pb : db) << 16) | op16;
      1: exp_ea = (db << 16) | ((op16 + xi) & 65535);
      2: exp_ea = (db << 16) | ((op16 + yi) & 65535);
      3: exp_ea = (d + op8) & 65535;
      4: exp_ea = (d + op8 + xi) & 65535;
      9: exp_ea = (sp + op8) & 65535;
      11: exp_ea = op;
      12: exp_ea = (op + xi) & 24'hFFFFFF;
      5, 6: begin nb = 2; base = (d + op8) & 65535; end
      7, 8: begin nb = 3; base = (d + op8) & 65535; end
      10: begin nb = 2; base = (sp + op8) & 65535; end
      default: exp_ea = op;
    endcase
    if (nb > 0) begin
      p = 0;
      for (int k = 0; k < nb; k++)
        p = p | (int'(memf(24'((base + k) & 65535))) << (8 * k));
      case (m)
        5: exp_ea = (db << 16) | p;
        6, 10: exp_ea = (db << 16) | ((p + yi) & 65535);
        7: exp_ea = p;
        default: exp_ea = (p + yi) & 24'hFFFFFF;
      endcase
    end
  endtask

  task automatic run(input string tag, input int m, input logic [23:0] op,
                     input bit ctl, input logic [15:0] x, input logic [15:0] y,
                     input logic [15:0] d, input logic [15:0] sp,
                     input logic [7:0] db, input logic [7:0] pb,
                     input bit i8, input bit poke);
    int exp_ea, nb, base, lat;
    model(m, int'(op), ctl, int'(x), int'(y), int'(d), int'(sp),
          int'(db), int'(pb), i8, exp_ea, nb, base);
    lat = (nb == 0) ? 1 : nb + 2;
    @(negedge clk);
    mode = 4'(m); opnd = op; ctl_flow = ctl; reg_x = x; reg_y = y;
    reg_d = d; reg_sp = sp; dbank = db; pbank = pb; idx8 = i8; start = 1'b1;
    for (int c = 1; c <= lat; c++) begin
      @(negedge clk);
      if (c == 1) begin
        // R13: scramble request inputs once accepted
        reg_x = ~x; reg_y = ~y; reg_d = d + 16'h0101; reg_sp = ~sp;
        dbank = ~db; pbank = ~pb; idx8 = ~i8; ctl_flow = ~ctl;
        opnd = op ^ 24'h5A5A5A;
        if (poke) begin mode = 4'd3; start = 1'b1; end
        else begin mode = 4'd11; start = 1'b0; end
      end else begin
        start = 1'b0;
      end
      chk("R11", "done", 32'(done), 32'(c == lat));
      chk("R11", "busy", 32'(busy), 32'(nb > 0 && c < lat));
      chk("R8", "rd_en", 32'(mem_rd_en), 32'(nb > 0 && c <= nb));
      if (nb > 0 && c <= nb)
        chk("R8", "rd_addr", 32'(mem_addr), 32'((base + c - 1) & 65535));
      if (c == lat) chk(tag, "ea", 32'(ea), 32'(exp_ea));
    end
    start = 1'b0;
    @(negedge clk);
    chk(poke ? "R12" : "R11", "no extra done", 32'(done), 32'h0);
    chk("R12", "idle read", 32'(mem_rd_en), 32'h0);
    if (poke) chk("R12", "ea held", 32'(ea), 32'(exp_ea));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "done", 32'(done), 32'h0);
    chk("R1", "busy", 32'(busy), 32'h0);
    chk("R1", "rd_en", 32'(mem_rd_en), 32'h0);
    chk("R1", "ea", 32'(ea), 32'h0);

    // R2 absolute, data bank and program bank
    run("R2", 0, 24'h00BEEF, 0, 16'h1111, 16'h2222, 16'h0300, 16'h01F0, 8'h7E, 8'h80, 0, 0);
    run("R2", 0, 24'h00BEEF, 1, 16'h1111, 16'h2222, 16'h0300, 16'h01F0, 8'h7E, 8'h80, 0, 0);
    // R3 absolute indexed, wrap inside 16 bits
    run("R3", 1, 24'h00FFF0, 0, 16'h0020, 16'h0000, 16'h0000, 16'h0000, 8'h12, 8'h00, 0, 0);
    run("R3", 2, 24'h001000, 0, 16'h0000, 16'hF234, 16'h0000, 16'h0000, 8'h34, 8'h00, 0, 0);
    // R4 narrow index
    run("R4", 1, 24'h00FFF0, 0, 16'h1234, 16'h0000, 16'h0000, 16'h0000, 8'h12, 8'h00, 1, 0);
    run("R4", 4, 24'h000010, 0, 16'hABCD, 16'h0000, 16'h2000, 16'h0000, 8'h00, 8'h00, 1, 0);
    run("R4", 6, 24'h000044, 0, 16'h0000, 16'hFFFF, 16'h0100, 16'h0000, 8'h55, 8'h00, 1, 0);
    // R5 direct page with wrap
    run("R5", 3, 24'h000020, 0, 16'h0000, 16'h0000, 16'hFFF0, 16'h0000, 8'h66, 8'h00, 0, 0);
    run("R5", 4, 24'h0000F0, 0, 16'h8000, 16'h0000, 16'h7F20, 16'h0000, 8'h66, 8'h00, 0, 0);
    // R6 stack relative
    run("R6", 9, 24'h000005, 0, 16'h0000, 16'h0000, 16'h0000, 16'hFFFE, 8'h66, 8'h00, 0, 0);
    // R7 long, long indexed with bank carry, unused code
    run("R7", 11, 24'h7E1234, 0, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 8'h00, 8'h00, 0, 0);
    run("R7", 12, 24'h12FFF0, 0, 16'h0020, 16'h0000, 16'h0000, 16'h0000, 8'h00, 8'h00, 0, 0);
    run("R7", 14, 24'hC0FFEE, 0, 16'h0020, 16'h0000, 16'h0000, 16'h0000, 8'h00, 8'h00, 0, 0);
    // R9 16-bit pointer modes, including a base that wraps at 0xFFFF
    run("R9", 5, 24'h000010, 0, 16'h0000, 16'h0000, 16'h0200, 16'h0000, 8'h7F, 8'h00, 0, 0);
    run("R9", 5, 24'h0000FF, 0, 16'h0000, 16'h0000, 16'hFF00, 16'h0000, 8'h7F, 8'h00, 0, 0);
    run("R9", 6, 24'h000033, 0, 16'h0000, 16'hFFF0, 16'h0400, 16'h0000, 8'h21, 8'h00, 0, 0);
    run("R9", 10, 24'h000003, 0, 16'h0000, 16'hE000, 16'h0000, 16'h01FC, 8'h44, 8'h00, 0, 0);
    // R10 long pointers, bank carry on indexed form
    run("R10", 7, 24'h000080, 0, 16'h0000, 16'h0000, 16'h1F00, 16'h0000, 8'h00, 8'h00, 0, 0);
    run("R10", 8, 24'h0000FE, 0, 16'h0000, 16'hFFFF, 16'hFF01, 16'h0000, 8'h00, 8'h00, 0, 0);
    // R12 start while busy is dropped
    run("R12", 6, 24'h000012, 0, 16'h0000, 16'h0101, 16'h0500, 16'h0000, 8'h0A, 8'h00, 0, 1);
    run("R12", 8, 24'h000012, 0, 16'h0000, 16'h0101, 16'h0500, 16'h0000, 8'h0A, 8'h00, 0, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule